// File: doc/BRIEF.md
# Serial Wiper Register with Cascade

This block is the digital control logic of a dual 256-tap digital potentiometer. It sits behind a 3-wire serial port made up of an active-high port enable, a serial clock and serial data. All three port lines are brought into a fast system clock through two-stage synchronisers, and the enable and clock edges are found by edge detection. While the port is enabled, each rising edge of the serial clock moves one data bit into a 17-bit shift register. The bit at the far end of that register is driven on a cascade output at all times, so several devices can share one port by chaining cascade output to data input.

A small state machine tracks the port. It has three states:
- `ST_IDLE`: the port is disabled.
- `ST_ACTIVE`: a transaction is under way.
- `ST_COMMIT`: a single cycle in which the register contents are copied to the two 8-bit wiper-position outputs and to the stack-select output.

The machine has four transitions:
- `ST_IDLE` goes to `ST_ACTIVE` on an enable rise.
- `ST_ACTIVE` goes to `ST_COMMIT` on an enable fall.
- `ST_COMMIT` goes to `ST_ACTIVE` if the enable has already risen again.
- Otherwise `ST_COMMIT` returns to `ST_IDLE`.

The stack-select output is the select line for the stacked wiper multiplexer. Nothing counts bits, so a short transaction commits a partly shifted register.

Top module: `serial_wiper_ctrl`

## Requirements
- R1: After the synchronous reset, the shift register, `wiper0_pos`, `wiper1_pos`, `stack_sel` and `casc_out` are all 0.
- R2: While `port_en` is low, activity on `port_clk` and `port_dat` changes neither the shift register nor any output.
- R3: While `port_en` is high, each rising edge of `port_clk` captures one `port_dat` bit into register bit 16, and every other bit moves one place toward bit 0.
- R4: A 17-bit transaction is sent in this order: first the stack-select bit, then `wiper1_pos` MSB first, then `wiper0_pos` MSB first. After the transaction, register bit 0 holds the stack-select bit, bits 1..8 hold wiper 1 (MSB at bit 1) and bits 9..16 hold wiper 0 (MSB at bit 9).
- R5: `casc_out` always equals register bit 0, whatever the state of `port_enen`, so the stack-select bit is the first bit to leave at the start of a transaction.
- R6: While the port is idle, `casc_out` equals the committed `stack_sel`.
- R7: `wiper0_pos`, `wiper1_pos` and `stack_sel` change only after a high-to-low transition of `port_en`. They keep their old values for the whole of a transaction.
- R8: No bits are counted. A transaction of any length other than 17 commits the register exactly as it was left partly shifted.
- R9: A `port_clk` rise that reaches the port in the same cycle as the `port_en` rise, or in the same cycle as the `port_en` fall, is not captured.
- R10: In a chain transaction of 34 bits, the first 17 bits leave on `casc_out` in the order they were sent, and the last 17 bits are committed.
- R11: `stack_sel` is the select for the stacked wiper multiplexer: 0 chooses wiper 0 and 1 chooses wiper 1. It holds the value committed from register bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `port_clk` |
| rst_n | input | 1 | Synchronous reset, active low |
| port_en | input | 1 | Serial port enable, active high, asynchronous |
| port_clk | input | 1 | Serial clock; data is captured on its rising edge |
| port_dat | input | 1 | Serial data in |
| casc_out | output | 1 | Cascade data out (register bit 0) |
| wiper0_pos | output | 8 | Committed wiper 0 tap position |
| wiper1_pos | output | 8 | Committed wiper 1 tap position |
| stack_sel | output | 1 | Stacked wiper multiplexer select (0 selects wiper 0, 1 selects wiper 1) |

## Verification
Two functions can land in the same system cycle: the capture of a serial clock edge and the opening or closing of the port by the enable. The bench provokes both cases by changing `port_clk` and `port_en` on the same system clock edge, at the start and at the end of a transaction. In the closing case it drives a data bit that would corrupt every field if it were shifted in. It then judges the committed wiper and stack-select outputs against a frame worked out arithmetically in the bench, and any extra or lost shift shows up there. A sweep over many wiper values, together with partial and chained transactions, covers the field map, the cascade order and the idle behaviour.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } swc_state_t;

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    initial begin
        if (STAGES < 2) $error("swc_sync: STAGES must be at least 2");
    end

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       pclk_s,
    output logic       shift_en,
    output logic       commit,
    output swc_state_t state
);

    logic       en_prev;
    logic       pclk_prev;
    logic       en_rise;
    logic       en_fall;
    logic       pclk_rise;
    swc_state_t state_nxt;

    assign en_rise   = en_s & ~en_prev;
    assign en_fall   = ~en_s & en_prev;
    assign pclk_rise = pclk_s & ~pclk_prev;

    // State register and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            en_prev   <= 1'b0;
            pclk_prev <= 1'b0;
        end else begin
            state     <= state_nxt;
            en_prev   <= en_s;
            pclk_prev <= pclk_s;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nxt = state;
        shift_en  = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en_rise) state_nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                shift_en = pclk_rise & en_s;
                if (en_fall) state_nxt = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit    = 1'b1;
                state_nxt = en_rise ? ST_ACTIVE : ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/swc_shreg.sv
module swc_shreg #(
    parameter int REG_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [REG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {din, q[REG_W-1:1]};
        end
    end

endmodule

// File: rtl/swc_wiper_out.sv
module swc_wiper_out #(
    parameter int WIPER_W = 8,
    localparam int REG_W  = 2 * WIPER_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [REG_W-1:0]   reg_q,
    output logic [WIPER_W-1:0] wiper0_pos,
    output logic [WIPER_W-1:0] wiper1_pos,
    output logic               stack_sel
);

    logic [WIPER_W-1:0] w0_map;
    logic [WIPER_W-1:0] w1_map;

    // Wiper 1 MSB sits nearest bit 0; wiper 0 follows it.
    for (genvar j = 0; j < WIPER_W; j++) begin : g_map
        assign w1_map[WIPER_W-1-j] = reg_q[1+j];
        assign w0_map[WIPER_W-1-j] = reg_q[1+WIPER_W+j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper0_pos <= '0;
            wiper1_pos <= '0;
            stack_sel  <= 1'b0;
        end else if (commit) begin
            wiper0_pos <= w0_map;
            wiper1_pos <= w1_map;
            stack_sel  <= reg_q[0];
        end
    end

endmodule

// File: rtl/serial_wiper_ctrl.sv
module serial_wiper_ctrl
    import swc_pkg::*;
#(
    parameter int WIPER_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               port_clk,
    input  logic               port_dat,
    output logic               casc_out,
    output logic [WIPER_W-1:0] wiper0_pos,
    output logic [WIPER_W-1:0] wiper1_pos,
    output logic               stack_sel
);

    localparam int REG_W = 2 * WIPER_W + 1;

    logic [2:0]       sync_v;
    logic             en_s;
    logic             pclk_s;
    logic             dat_s;
    logic             shift_en;
    logic             commit;
    swc_state_t       state;
    logic [REG_W-1:0] shreg_q;

    swc_sync #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({port_dat, port_clk, port_en}),
        .sync_out (sync_v)
    );

    assign en_s   = sync_v[0];
    assign pclk_s = sync_v[1];
    assign dat_s  = sync_v[2];

    swc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (en_s),
        .pclk_s   (pclk_s),
        .shift_en (shift_en),
        .commit   (commit),
        .state    (state)
    );

    swc_shreg #(.REG_W(REG_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (dat_s),
        .q        (shreg_q)
    );

    swc_wiper_out #(.WIPER_W(WIPER_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .reg_q      (shreg_q),
        .wiper0_pos (wiper0_pos),
        .wiper1_pos (wiper1_pos),
        .stack_sel  (stack_sel)
    );

    assign casc_out = shreg_q[0];

endmodule

// File: rtl/swc_checker.sv
module swc_checker
    import swc_pkg::*;
#(
    parameter int WIPER_W = 8,
    localparam int REG_W  = 2 * WIPER_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_s,
    input logic               pclk_s,
    input logic               dat_s,
    input swc_state_t         state,
    input logic [REG_W-1:0]   shreg_q,
    input logic               casc_out,
    input logic [WIPER_W-1:0] wiper0_pos,
    input logic [WIPER_W-1:0] wiper1_pos,
    input logic               stack_sel
);

    logic pclk_d;
    logic pclk_up;

    always_ff @(posedge clk) begin
        if (!rst_n) pclk_d <= 1'b0;
        else        pclk_d <= pclk_s;
    end

    assign pclk_up = pclk_s & ~pclk_d;

    // R2: a disabled port leaves the register untouched
    a_r2_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> $stable(shreg_q));

    // R3: a captured edge enters at the top and shifts toward bit 0
    a_r3_shift_in_top: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && pclk_up && en_s) |=>
            (shreg_q == {$past(dat_s), $past(shreg_q[REG_W-1:1])}));

    // R7: outputs move only out of the commit state
    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable({wiper0_pos, wiper1_pos, stack_sel}));

    // R4 / R11: commit takes the stack-select bit and the wiper MSBs from their places
    a_r4_commit_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=>
            (stack_sel == $past(shreg_q[0]) &&
             wiper1_pos[WIPER_W-1] == $past(shreg_q[1]) &&
             wiper0_pos[WIPER_W-1] == $past(shreg_q[WIPER_W+1])));

    // R6: idle cascade shows the committed stack select
    a_r6_idle_casc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (casc_out == stack_sel));

endmodule

bind serial_wiper_ctrl swc_checker #(.WIPER_W(WIPER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_s       (en_s),
    .pclk_s     (pclk_s),
    .dat_s      (dat_s),
    .state      (state),
    .shreg_q    (shreg_q),
    .casc_out   (casc_out),
    .wiper0_pos (wiper0_pos),
    .wiper1_pos (wiper1_pos),
    .stack_sel  (stack_sel)
);

// File: tb/serial_wiper_ctrl_bench.sv
module serial_wiper_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       port_clk = 1'b0;
    logic       port_dat = 1'b0;
    logic       casc_out;
    logic [7:0] wiper0_pos;
    logic [7:0] wiper1_pos;
    logic       stack_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [16:0] mreg = '0;
    logic [7:0]  e_w0 = '0;
    logic [7:0]  e_w1 = '0;
    logic        e_ss = 1'b0;

    always #2 clk = ~clk;

    serial_wiper_ctrl u_serial_wiper_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .port_clk   (port_clk),
        .port_dat   (port_dat),
        .casc_out   (casc_out),
        .wiper0_pos (wiper0_pos),
        .wiper1_pos (wiper1_pos),
        .stack_sel  (stack_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bit k of a frame: k=0 stack select, 1..8 wiper1 MSB first, 9..16 wiper0 MSB first
    function automatic logic frame_bit(input logic [7:0] w0, input logic [7:0] w1,
                                       input logic ss, input int k);
        if (k == 0)      return ss;
        else if (k <= 8) return w1[8-k];
        else             return w0[16-k];
    endfunction

    task automatic pbit(input logic b);
        port_dat = b;
        tick(3);
        port_clk = 1'b1;
        tick(6);
        port_clk = 1'b0;
        tick(3);
        if (port_en) mreg = {b, mreg[16:1]};
    endtask

    task automatic open_tx();
        port_en = 1'b1;
        tick(6);
    endtask

    task automatic close_tx();
        tick(3);
        port_en = 1'b0;
        tick(8);
        e_ss = mreg[0];
        for (int j = 0; j < 8; j++) begin
            e_w1[7-j] = mreg[1+j];
            e_w0[7-j] = mreg[9+j];
        end
    endtask

    task automatic check_outs(input string req);
        chk({req, " wiper0"}, {24'd0, wiper0_pos}, {24'd0, e_w0});
        chk({req, " wiper1"}, {24'd0, wiper1_pos}, {24'd0, e_w1});
        chk({req, " stack_sel"}, {31'd0, stack_sel}, {31'd0, e_ss});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] w0, w1;
        logic       ss;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state
        check_outs("R1 reset");
        chk("R1 casc_out", {31'd0, casc_out}, 32'd0);

        // R4/R5/R6/R7/R11: sweep of frames
        for (int i = 0; i < 44; i++) begin
            case (i)
                0: begin w0 = 8'h00; w1 = 8'h00; ss = 1'b0; end
                1: begin w0 = 8'hFF; w1 = 8'hFF; ss = 1'b1; end
                2: begin w0 = 8'h80; w1 = 8'h01; ss = 1'b0; end
                3: begin w0 = 8'h01; w1 = 8'h80; ss = 1'b1; end
                default: begin
                    w0 = 8'((i * 37 + 5) & 255);
                    w1 = 8'((i * 101 + 200) & 255);
                    ss = i[0];
                end
            endcase
            open_tx();
            for (int k = 0; k < 17; k++) begin
                if (i < 3) chk("R5 casc before bit", {31'd0, casc_out}, {31'd0, mreg[0]});
                pbit(frame_bit(w0, w1, ss, k));
            end
            check_outs("R7 held during transaction");
            close_tx();
            chk("R4 wiper0 field", {24'd0, wiper0_pos}, {24'd0, w0});
            chk("R4 wiper1 field", {24'd0, wiper1_pos}, {24'd0, w1});
            chk("R11 stack_sel", {31'd0, stack_sel}, {31'd0, ss});
            chk("R6 idle casc", {31'd0, casc_out}, {31'd0, ss});
        end

        // R2: clock and data with port disabled
        for (int k = 0; k < 10; k++) pbit(k[0] ^ ~e_ss);
        chk("R2 casc unchanged", {31'd0, casc_out}, {31'd0, e_ss});
        check_outs("R2 outputs unchanged");
        open_tx();
        close_tx();
        check_outs("R2 register unchanged");

        // R8: partial transaction of 5 bits, then 20 bits
        open_tx();
        for (int k = 0; k < 5; k++) pbit(k[1] | k[0]);
        close_tx();
        check_outs("R8 partial 5");
        open_tx();
        for (int k = 0; k < 20; k++) pbit(k[2]);
        close_tx();
        check_outs("R8 partial 20");

        // R10: chain of two frames
        open_tx();
        for (int k = 0; k < 17; k++) pbit(frame_bit(8'h3C, 8'hC3, 1'b1, k));
        for (int k = 0; k < 17; k++) begin
            chk("R10 casc order", {31'd0, casc_out},
                {31'd0, frame_bit(8'h3C, 8'hC3, 1'b1, k)});
            pbit(frame_bit(8'h96, 8'h69, 1'b0, k));
        end
        close_tx();
        chk("R10 wiper0", {24'd0, wiper0_pos}, 32'h96);
        chk("R10 wiper1", {24'd0, wiper1_pos}, 32'h69);
        chk("R10 stack_sel", {31'd0, stack_sel}, 32'd0);

        // R9: clock edges coinciding with enable rise and enable fall
        port_dat = 1'b1;
        tick(2);
        port_en = 1'b1;
        port_clk = 1'b1;
        tick(6);
        port_clk = 1'b0;
        tick(6);
        for (int k = 0; k < 17; k++) pbit(frame_bit(8'hA5, 8'h5A, 1'b1, k));
        port_dat = 1'b0;
        tick(3);
        port_clk = 1'b1;
        port_en = 1'b0;
        tick(6);
        port_clk = 1'b0;
        tick(8);
        chk("R9 wiper0", {24'd0, wiper0_pos}, 32'hA5);
        chk("R9 wiper1", {24'd0, wiper1_pos}, 32'h5A);
        chk("R9 stack_sel", {31'd0, stack_sel}, 32'd1);
        chk("R9 casc", {31'd0, casc_out}, 32'd1);

        // R3: one bit then close; the bit lands at position 16 (wiper0 LSB)
        mreg = {8'hA5 & 8'h00, 8'h00, 1'b0} | {1'b0, 8'h00, 8'h00};
        mreg = '0;
        for (int j = 0; j < 8; j++) begin
            mreg[9+j] = 1'b0;
        end
        mreg[0] = 1'b1;
        for (int j = 0; j < 8; j++) begin
            mreg[1+j] = 8'h5A >> (7 - j);
            mreg[9+j] = 8'hA5 >> (7 - j);
        end
        open_tx();
        pbit(1'b1);
        close_tx();
        chk("R3 wiper0 after one bit", {24'd0, wiper0_pos}, {24'd0, e_w0});
        chk("R3 stack_sel after one bit", {31'd0, stack_sel}, {31'd0, 1'b1 & 8'h5A});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule